// File: doc/BRIEF.md
# Attribute Register Access Port

This block is the host-facing access logic for a small attribute register file in a display controller. The host writes through one shared byte port. A hidden phase flip-flop decides whether each write is an index or a data byte. The first write after the flip-flop is cleared selects a register, and the next write loads that register. Reading the input status register clears the flip-flop as a side effect, so software can always get back to a known phase before it starts a write pair.

The index byte has two jobs. Its low five bits select a register. Bit 5 turns video output on. While that bit is clear, the host owns the palette and the display is not fed from it. A separate read strobe returns the selected register one cycle later and leaves the phase alone.

The file holds sixteen 6-bit palette entries and five control bytes: mode, overscan colour, plane enable, pixel panning and colour select. The panning shift and the plane mask go straight out to the pixel pipeline.

Top module: `attr_port`

## Requirements
- R1: Every write to the shared port toggles the phase, whatever the index holds. In index phase the byte is taken as an index, and in data phase it is taken as data for the stored index.
- R2: A status read puts the phase back to index. If a write arrives in the same cycle, that write is handled in its current phase, and the phase is still index afterwards.
- R3: On an index write, bits 4..0 become the stored index and bit 5 becomes `videoEn`, which changes on the cycle after the write.
- R4: A pulse on `rdEn` loads `rdData` on the next clock with the register chosen by the stored index. Otherwise `rdData` holds its value. Reads never change the phase.
- R5: Indices 0x00 to 0x0F select palette entries. Each entry keeps bits 5..0 of the data byte and reads back with bits 7..6 zero.
- R6: Index 0x12 is the plane-enable register. It keeps bits 3..0, which drive `planeMask`. Index 0x13 is the pixel-panning register. It keeps bits 2..0, which drive `pixelPan` (a shift of 0 to 7). Both read back with their other bits zero.
- R7: Indices 0x10 (mode), 0x11 (overscan colour) and 0x14 (colour select) keep all 8 data bits.
- R8: Data writes to an index from 0x15 to 0x1F change no register, and a read of such an index returns zero.
- R9: After reset the phase is index, video is off, the stored index is 0, every register is zero and `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the shared index/data port |
| wrData | input | 8 | Byte written through the shared port |
| statusRd | input | 1 | Pulse marking a read of the input status register |
| rdEn | input | 1 | Read strobe for the data read port |
| rdData | output | 8 | Registered value of the selected register |
| videoEn | output | 1 | Video enable, taken from bit 5 of the last index byte |
| pixelPan | output | 3 | Pixel panning shift |
| planeMask | output | 4 | Plane enable mask |

## Verification
The bench targets phase tracking in several ways. It abandons a half-finished pair by reading the status register, issues a status read in the same cycle as a data write, interleaves data reads between index and data writes, and sends a data write to an out-of-range index. A design that skipped the toggle on out-of-range indices, or that let reads move the phase, would treat the following byte as data and corrupt a register. A design that let the status read take priority over a same-cycle write would lose that write. The bench also writes all-ones data into the narrow registers. A design that stored too many bits would then show them on read-back or on `planeMask` and `pixelPan`.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 5;
  localparam int PAL_N   = 16;
  localparam int PAL_W   = 6;
  localparam int VID_BIT = 5;
  localparam int PLANE_W = 4;
  localparam int PAN_W   = 3;

  localparam logic [IDX_W-1:0] IDX_MODE  = 5'h10;
  localparam logic [IDX_W-1:0] IDX_OVSC  = 5'h11;
  localparam logic [IDX_W-1:0] IDX_PLANE = 5'h12;
  localparam logic [IDX_W-1:0] IDX_PAN   = 5'h13;
  localparam logic [IDX_W-1:0] IDX_CSEL  = 5'h14;

  typedef struct packed {
    logic idxWr;
    logic dataWr;
  } attrStrobe_t;
endpackage

// File: rtl/attr_ctrl.sv
module attr_ctrl
  import attr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        statusRd,
  output attrStrobe_t strb
);
  // dataPhase = 1 means the next write is a data byte
  logic dataPhase;
  logic dataPhaseNext;

  always_comb begin
    dataPhaseNext = dataPhase;
    if (wrEn)     dataPhaseNext = ~dataPhase;
    if (statusRd) dataPhaseNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataPhase <= 1'b0;
    else       dataPhase <= dataPhaseNext;
  end

  always_comb begin
    strb.idxWr  = wrEn & ~dataPhase;
    strb.dataWr = wrEn &  dataPhase;
  end

  assert_toggle_flip_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !statusRd) |=> (dataPhase != $past(dataPhase)));

  assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !statusRd) |=> $stable(dataPhase));

  assert_status_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |=> !dataPhase);

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.idxWr, strb.dataWr}));
endmodule

// File: rtl/attr_regs.sv
module attr_regs
  import attr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W,
  parameter int PN = PAL_N,
  parameter int PW = PAL_W,
  parameter int VB = VID_BIT,
  parameter int MW = PLANE_W,
  parameter int SW = PAN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  attrStrobe_t   strb,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic          videoEn,
  output logic [SW-1:0] pixelPan,
  output logic [MW-1:0] planeMask
);
  localparam int PIW = $clog2(PN);

  logic [IW-1:0] idxReg;
  logic [PW-1:0] palReg [PN];
  logic [DW-1:0] modeReg, ovscReg, cselReg;
  logic [MW-1:0] planeReg;
  logic [SW-1:0] panReg;
  logic [DW-1:0] selVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg  <= '0;
      videoEn <= 1'b0;
    end else if (strb.idxWr) begin
      idxReg  <= wrData[IW-1:0];
      videoEn <= wrData[VB];
    end
  end

  for (genvar g = 0; g < PN; g++) begin : gPal
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) palReg[g] <= '0;
      else if (strb.dataWr && (idxReg == IW'(g))) palReg[g] <= wrData[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      ovscReg  <= '0;
      cselReg  <= '0;
      planeReg <= '0;
      panReg   <= '0;
    end else if (strb.dataWr) begin
      case (idxReg)
        IDX_MODE:  modeReg  <= wrData;
        IDX_OVSC:  ovscReg  <= wrData;
        IDX_PLANE: planeReg <= wrData[MW-1:0];
        IDX_PAN:   panReg   <= wrData[SW-1:0];
        IDX_CSEL:  cselReg  <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    selVal = '0;
    if (idxReg < IW'(PN)) begin
      selVal[PW-1:0] = palReg[idxReg[PIW-1:0]];
    end else begin
      case (idxReg)
        IDX_MODE:  selVal = modeReg;
        IDX_OVSC:  selVal = ovscReg;
        IDX_PLANE: selVal[MW-1:0] = planeReg;
        IDX_PAN:   selVal[SW-1:0] = panReg;
        IDX_CSEL:  selVal = cselReg;
        default:   selVal = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= selVal;
  end

  always_comb begin
    pixelPan  = panReg;
    planeMask = planeReg;
  end

  assert_video_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.idxWr |=> (videoEn == $past(wrData[VB])));

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_ignore_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && (idxReg > IDX_CSEL)) |=>
      ($stable(modeReg) && $stable(ovscReg) && $stable(cselReg)
       && $stable(planeReg) && $stable(panReg)));
endmodule

// File: rtl/attr_port.sv
module attr_port
  import attr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               statusRd,
  input  logic               rdEn,
  output logic [DATA_W-1:0]  rdData,
  output logic               videoEn,
  output logic [PAN_W-1:0]   pixelPan,
  output logic [PLANE_W-1:0] planeMask
);
  attrStrobe_t strb;

  attr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .statusRd(statusRd), .strb(strb)
  );

  attr_regs i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .videoEn(videoEn), .pixelPan(pixelPan),
    .planeMask(planeMask)
  );
endmodule

// File: tb/test_attr_port.sv
`timescale 1ns/1ps
module test_attr_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic statusRd = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] rdData;
  logic videoEn;
  logic [2:0] pixelPan;
  logic [3:0] planeMask;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  attr_port i_attr_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .statusRd(statusRd),
    .rdEn(rdEn), .rdData(rdData), .videoEn(videoEn), .pixelPan(pixelPan),
    .planeMask(planeMask)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic portWrite(input logic [7:0] b, input logic withStatus = 1'b0);
    @(negedge clk);
    wrEn = 1'b1; wrData = b; statusRd = withStatus;
    @(negedge clk);
    wrEn = 1'b0; statusRd = 1'b0;
  endtask

  task automatic statusRead();
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  task automatic dataRead(output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [7:0] val);
    portWrite(idx);
    portWrite(val);
  endtask

  task automatic regRead(input logic [7:0] idx, output logic [7:0] v);
    portWrite(idx);
    dataRead(v);
    statusRead();
  endtask

  task automatic testReset();
    check("R9 videoEn", {7'b0, videoEn}, 8'h00);
    check("R9 pixelPan", {5'b0, pixelPan}, 8'h00);
    check("R9 planeMask", {4'b0, planeMask}, 8'h00);
    check("R9 rdData", rdData, 8'h00);
  endtask

  task automatic testAlternate();
    logic [7:0] v;
    regWrite(8'h33, 8'h05);
    check("R1 pan via pair", {5'b0, pixelPan}, 8'h05);
    check("R3 video set", {7'b0, videoEn}, 8'h01);
    portWrite(8'h32);
    portWrite(8'h0A);
    check("R1 second pair", {4'b0, planeMask}, 8'h0A);
    dataRead(v);
    check("R1 readback plane", v, 8'h0A);
  endtask

  task automatic testStatusClear();
    portWrite(8'h33);
    statusRead();
    regWrite(8'h32, 8'h07);
    check("R2 abandoned pair", {4'b0, planeMask}, 8'h07);
    check("R2 pan untouched", {5'b0, pixelPan}, 8'h05);
    portWrite(8'h32);
    portWrite(8'h0B, 1'b1);
    check("R2 same-cycle write kept", {4'b0, planeMask}, 8'h0B);
    regWrite(8'h33, 8'h02);
    check("R2 index after same-cycle", {5'b0, pixelPan}, 8'h02);
    check("R2 plane not hit", {4'b0, planeMask}, 8'h0B);
  endtask

  task automatic testVideoBit();
    portWrite(8'h12);
    check("R3 video clear", {7'b0, videoEn}, 8'h00);
    portWrite(8'h04);
    check("R3 data no video change", {7'b0, videoEn}, 8'h00);
    portWrite(8'h32);
    check("R3 video set again", {7'b0, videoEn}, 8'h01);
    portWrite(8'h0C);
  endtask

  task automatic testReadNoToggle();
    logic [7:0] v;
    portWrite(8'h32);
    dataRead(v);
    check("R4 read value", v, 8'h0C);
    dataRead(v);
    repeat (3) @(negedge clk);
    check("R4 rdData holds", rdData, 8'h0C);
    portWrite(8'h09);
    check("R4 write after reads is data", {4'b0, planeMask}, 8'h09);
  endtask

  task automatic testPalette();
    logic [7:0] v;
    regWrite(8'h03, 8'hFF);
    regWrite(8'h0F, 8'h2A);
    regRead(8'h03, v);
    check("R5 palette 3 width", v, 8'h3F);
    regRead(8'h0F, v);
    check("R5 palette 15", v, 8'h2A);
    regRead(8'h00, v);
    check("R5 palette 0 untouched", v, 8'h00);
  endtask

  task automatic testPanPlane();
    logic [7:0] v;
    regWrite(8'h13, 8'hFE);
    check("R6 pan low bits", {5'b0, pixelPan}, 8'h06);
    regWrite(8'h12, 8'hF3);
    check("R6 plane low bits", {4'b0, planeMask}, 8'h03);
    regRead(8'h13, v);
    check("R6 pan readback", v, 8'h06);
    regRead(8'h12, v);
    check("R6 plane readback", v, 8'h03);
  endtask

  task automatic testFullBytes();
    logic [7:0] v;
    regWrite(8'h10, 8'hA5);
    regWrite(8'h11, 8'h5A);
    regWrite(8'h14, 8'hC3);
    regRead(8'h10, v);
    check("R7 mode", v, 8'hA5);
    regRead(8'h11, v);
    check("R7 overscan", v, 8'h5A);
    regRead(8'h14, v);
    check("R7 colour select", v, 8'hC3);
  endtask

  task automatic testHighIndex();
    logic [7:0] v;
    regWrite(8'h15, 8'h77);
    regWrite(8'h1F, 8'hEE);
    regRead(8'h15, v);
    check("R8 high index reads zero", v, 8'h00);
    regRead(8'h14, v);
    check("R8 csel unchanged", v, 8'hC3);
    check("R8 plane unchanged", {4'b0, planeMask}, 8'h03);
    portWrite(8'h15);
    portWrite(8'h55);
    portWrite(8'h12);
    portWrite(8'h04);
    check("R1 toggle flips on ignored write", {4'b0, planeMask}, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAlternate();
    testStatusClear();
    testVideoBit();
    testReadNoToggle();
    testPalette();
    testPanPlane();
    testFullBytes();
    testHighIndex();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule